// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down counter advances only on cycles where the `tick` enable is high, so a slow counting rate can be derived from a fast system clock. Software loads an initial count and a mode number in one cycle. The channel then produces an output waveform and a live count value. The waveform can be an interrupt on terminal count, a one-shot, a rate pulse, a square wave, or a software- or hardware-started strobe.

A `gate` input controls the channel in one of two ways, depending on the mode. In some modes it is a level enable. In others its rising edge starts or restarts the count from the initial value. Both outputs are registered, so a load, gate edge or tick sampled at one clock edge shows on `out` and `count` after that edge. A `count` value of 0 is loaded as 65536. In modes that do not reload, the counter wraps past zero to 0xFFFF instead of stopping. Byte sequencing, bus decoding and status readback belong to the surrounding logic.

Top module: `ivt_channel`

## Requirements
- R1: After synchronous reset, `out` is 0 and `count` is 0. Until the first load, neither `tick` nor any gate edge changes either output.
- R2: On a load cycle, `mode` is captured and the loaded value appears on `count` after that clock edge. A load takes priority over a tick or a gate edge in the same cycle.
- R3: The count advances only on cycles where `tick` is high. In modes 0, 2, 3 and 4, `gate` must also be high for the count to advance. In modes 1 and 5, the gate level has no effect.
- R4: A gate rising edge is a cycle where `gate` is 1 and was 0 in the previous cycle. In modes 1, 2, 3 and 5, a rising edge restarts counting from the initial count. In modes 0 and 4, a rising edge does not restart counting.
- R5: Mode 0: `out` goes low on load. It goes high once the number of counted ticks reaches the initial count, and it stays high until the next load.
- R6: Mode 1: after a load, `out` is high and the count holds until a gate rising edge. From that edge, `out` is low until the number of counted ticks reaches the initial count, and then it is high.
- R7: Mode 2: the count runs N, N-1, …, 1 and then reloads N. `out` is high for exactly the counted-tick interval that follows each reload, and it is low at the start.
- R8: Mode 3: `out` is high for the first (N+1)/2 counted ticks of each N-tick period and low for the rest. The count steps down by 2 from N in the high half, and by 2 from N rounded down to even in the low half. With N=1, `out` stays high.
- R9: Modes 4 and 5: `out` is high for exactly one counted-tick interval, when the number of counted ticks equals the initial count, and is low otherwise. In mode 5, counting begins at a gate rising edge, and `out` stays low until then.
- R10: In modes 0, 1, 4 and 5, the counter does not stop at zero. The tick after 0 shows 0xFFFF, and the decrement continues.
- R11: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R12: A loaded value of 0 is treated as an initial count of 65536. `count` shows its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse from the fixed-rate timebase |
| gate | input | 1 | Gate: level enable or restart trigger, depending on the mode |
| load | input | 1 | Strobe that loads `load_val` and captures `mode` |
| load_val | input | 16 | Initial count (0 means 65536) |
| mode | input | 3 | Counting mode 0 to 7 (6 and 7 alias 2 and 3) |
| out | output | 1 | Registered channel output waveform |
| count | output | 16 | Registered current count value |

## Verification
On every cycle, the assertions check that a load shows up on `count`, and that the state stays frozen when there is no tick or when a gate-enabled mode has `gate` low. They also check that mode 0 keeps its output high, that a mode 2 pulse coincides with the reload value, and that a strobe lasts only one counted tick. Only the bench scenarios can show the full waveform shapes, because those depend on the number of ticks since the start. These include the odd and even square-wave halves, the wrap through 0xFFFF, the zero-as-65536 load, and the restart-versus-no-restart difference between modes. The scenarios also cover the mode aliases and load priority.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    MD_TC_IRQ    = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } ivt_mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic ivt_mode_e fold_mode(input logic [2:0] m);
    if (m[2] && m[1]) return ivt_mode_e'({1'b0, m[1:0]});
    return ivt_mode_e'(m);
  endfunction

  function automatic logic gate_level_ignored(input ivt_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_HW_STROBE);
  endfunction

  function automatic logic gate_edge_restarts(input ivt_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) ||
           (m == MD_SQUARE)  || (m == MD_HW_STROBE);
  endfunction

endpackage

// File: rtl/ivt_cfg.sv
module ivt_cfg
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_in,
  output logic [CW:0]   ld_init,
  output ivt_mode_e     ld_mode,
  output logic [CW:0]   init_q,
  output ivt_mode_e     mode_q,
  output logic          loaded_q
);

  localparam logic [CW:0] FULL_RANGE = {1'b1, {CW{1'b0}}};

  always_comb begin
    ld_init = (load_val == '0) ? FULL_RANGE : {1'b0, load_val};
    ld_mode = fold_mode(mode_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q   <= '0;
      mode_q   <= MD_TC_IRQ;
      loaded_q <= 1'b0;
    end else if (load) begin
      init_q   <= ld_init;
      mode_q   <= ld_mode;
      loaded_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign rise = gate && !gate_q;

endmodule

// File: rtl/ivt_core.sv
module ivt_core
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          gate_rise,
  input  logic          load,
  input  logic [CW:0]   ld_init,
  input  ivt_mode_e     ld_mode,
  input  logic [CW:0]   init_q,
  input  ivt_mode_e     mode_q,
  input  logic          loaded_q,
  output logic          out_q,
  output logic [CW-1:0] count_o
);

  localparam int          W      = CW + 1;
  localparam logic [W-1:0] WRAP_V = {1'b0, {CW{1'b1}}};

  logic [W-1:0] cnt_q;
  logic         run_q, hi_q, tc_q;
  logic         restart, gate_ok, step, last_one, tc_hit, pulse_mode;

  always_comb begin
    restart    = loaded_q && gate_rise && gate_edge_restarts(mode_q);
    gate_ok    = gate_level_ignored(mode_q) || gate;
    step       = loaded_q && run_q && tick && gate_ok;
    last_one   = (cnt_q == W'(1));
    tc_hit     = last_one && !tc_q;
    pulse_mode = (mode_q == MD_SW_STROBE) || (mode_q == MD_HW_STROBE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      run_q <= 1'b0;
      hi_q  <= 1'b1;
      tc_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= ld_init;
      tc_q  <= 1'b0;
      hi_q  <= 1'b1;
      run_q <= !gate_level_ignored(ld_mode);
      out_q <= (ld_mode == MD_ONESHOT) || (ld_mode == MD_SQUARE);
    end else if (restart) begin
      cnt_q <= init_q;
      tc_q  <= 1'b0;
      hi_q  <= 1'b1;
      run_q <= 1'b1;
      out_q <= (mode_q == MD_SQUARE);
    end else if (step) begin
      unique case (mode_q)
        MD_RATE: begin
          if (last_one) begin
            cnt_q <= init_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - W'(1);
            out_q <= 1'b0;
          end
        end
        MD_SQUARE: begin
          if (cnt_q <= W'(2)) begin
            if (init_q == W'(1)) begin
              cnt_q <= init_q;
              out_q <= 1'b1;
              hi_q  <= 1'b1;
            end else if (hi_q) begin
              cnt_q <= init_q - {{CW{1'b0}}, init_q[0]};
              out_q <= 1'b0;
              hi_q  <= 1'b0;
            end else begin
              cnt_q <= init_q;
              out_q <= 1'b1;
              hi_q  <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - W'(2);
          end
        end
        default: begin
          cnt_q <= (cnt_q == '0) ? WRAP_V : cnt_q - W'(1);
          if (tc_hit) tc_q <= 1'b1;
          if (pulse_mode) out_q <= tc_hit;
          else            out_q <= out_q || tc_hit;
        end
      endcase
    end
  end

  assign count_o = cnt_q[CW-1:0];

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode,
  output logic          out,
  output logic [CW-1:0] count
);

  logic [CW:0] ld_init, init_q;
  ivt_mode_e   ld_mode, mode_q;
  logic        loaded_q, gate_rise;

  ivt_cfg #(.CW(CW)) cfg_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .mode_in(mode),
    .ld_init(ld_init), .ld_mode(ld_mode), .init_q(init_q), .mode_q(mode_q),
    .loaded_q(loaded_q)
  );

  ivt_gate_edge edge_i (
    .clk(clk), .rst(rst), .gate(gate), .rise(gate_rise)
  );

  ivt_core #(.CW(CW)) core_i (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .gate_rise(gate_rise),
    .load(load), .ld_init(ld_init), .ld_mode(ld_mode), .init_q(init_q),
    .mode_q(mode_q), .loaded_q(loaded_q), .out_q(out), .count_o(count)
  );

endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          gate,
  input logic          load,
  input logic [CW-1:0] load_val,
  input logic          out,
  input logic [CW-1:0] count,
  input ivt_mode_e     mode_q,
  input logic [CW:0]   init_q
);

  logic gate_prev;
  always_ff @(posedge clk) begin
    if (rst) gate_prev <= 1'b0;
    else     gate_prev <= gate;
  end

  logic edge_seen, level_mode;
  assign edge_seen  = gate && !gate_prev;
  assign level_mode = (mode_q == MD_TC_IRQ) || (mode_q == MD_RATE) ||
                      (mode_q == MD_SQUARE) || (mode_q == MD_SW_STROBE);

  AST_LOAD_SHOWS_VALUE: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val)); // R2

  AST_IDLE_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick && !edge_seen) |=> ($stable(count) && $stable(out))); // R3

  AST_GATE_LOW_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (level_mode && !gate && !load) |=> ($stable(count) && $stable(out))); // R3

  AST_MODE0_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_TC_IRQ && out && !load) |=> out); // R5

  AST_RATE_PULSE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RATE && out) |-> count == init_q[CW-1:0]); // R7

  AST_STROBE_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst)
    (out && tick && !load &&
     ((mode_q == MD_SW_STROBE && gate) || (mode_q == MD_HW_STROBE && !edge_seen)))
    |=> !out); // R9

endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
  .load_val(load_val), .out(out), .count(count), .mode_q(mode_q),
  .init_q(init_q)
);

// File: tb/ivt_channel_tb_top.sv
module ivt_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst, tick, gate, load;
  logic [15:0] load_val;
  logic [2:0]  mode;
  logic        out;
  logic [15:0] count;

  always #10 clk = ~clk;

  ivt_channel dut_i (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
    .load_val(load_val), .mode(mode), .out(out), .count(count)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  // behavioural reference: elapsed counted ticks since start
  bit m_loaded = 0, m_started = 0, m_gprev = 0;
  int m_n = 0, m_mode = 0, m_d = 0;

  function automatic void expect_now(output int eo, output int ec);
    int p, h;
    if (!m_loaded) begin
      eo = 0; ec = 0;
    end else if (!m_started) begin
      eo = (m_mode == 1); ec = m_n & 16'hFFFF;
    end else begin
      case (m_mode)
        0, 1: begin eo = (m_d >= m_n); ec = (m_n - m_d) & 16'hFFFF; end
        4, 5: begin eo = (m_d == m_n); ec = (m_n - m_d) & 16'hFFFF; end
        2: begin
          p  = m_d % m_n;
          eo = (m_d > 0 && p == 0);
          ec = (m_n - p) & 16'hFFFF;
        end
        default: begin
          p = m_d % m_n;
          h = (m_n + 1) / 2;
          eo = (p < h);
          if (p < h) ec = (m_n - 2 * p) & 16'hFFFF;
          else       ec = ((m_n - (m_n % 2)) - 2 * (p - h)) & 16'hFFFF;
        end
      endcase
    end
  endfunction

  function automatic void advance(input bit t, input bit g, input bit ld,
                                  input int v, input int md);
    int fm;
    fm = (md > 5) ? md - 4 : md;
    if (ld) begin
      m_n = (v == 0) ? 65536 : v;
      m_mode = fm; m_loaded = 1; m_d = 0;
      m_started = !(fm == 1 || fm == 5);
    end else if (m_loaded && g && !m_gprev &&
                 (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
      m_d = 0; m_started = 1;
    end else if (m_loaded && m_started && t &&
                 (m_mode == 1 || m_mode == 5 || g)) begin
      m_d++;
    end
    m_gprev = g;
  endfunction

  task automatic check_now();
    int eo, ec;
    expect_now(eo, ec);
    checks++;
    if (out !== eo[0] || count !== ec[15:0]) begin
      errors++;
      $display("FAIL %s: out=%0d count=%0h, expected out=%0d count=%0h",
               cur_req, out, count, eo, ec);
    end
  endtask

  task automatic step(input bit t, input bit g, input bit ld,
                      input int v, input int md);
    @(negedge clk);
    check_now();
    tick = t; gate = g; load = ld; load_val = v[15:0]; mode = md[2:0];
    advance(t, g, ld, v, md);
  endtask

  task automatic run(input int n, input bit t, input bit g);
    for (int i = 0; i < n; i++) step(t, g, 0, 0, 0);
  endtask

  task automatic run_alt(input int n, input bit g);
    for (int i = 0; i < n; i++) step(i % 2 == 0, g, 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; tick = 0; gate = 0; load = 0; load_val = '0; mode = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R1";   // idle before any load, gate edges ignored
    for (int i = 0; i < 6; i++) step(1, i % 2, 0, 0, 0);

    cur_req = "R12";  // zero loads as 65536
    step(0, 1, 1, 0, 0);
    run(4, 1, 1);

    cur_req = "R5";
    step(0, 1, 1, 3, 0);
    run(4, 1, 1);
    cur_req = "R10";  // wrap through 0xFFFF, out stays high
    run(4, 1, 1);

    cur_req = "R3";   // gate level enable in mode 0, tick required
    step(0, 0, 1, 6, 0);
    run(3, 1, 0);
    run(2, 0, 1);
    run_alt(8, 1);

    cur_req = "R4";   // mode 4: gate rises do not restart
    step(0, 1, 1, 5, 4);
    for (int i = 0; i < 10; i++) step(1, i % 3 != 1, 0, 0, 0);
    cur_req = "R9";
    run(5, 1, 1);

    cur_req = "R6";   // one-shot waits for trigger
    step(0, 0, 1, 4, 1);
    run(3, 1, 0);
    run(3, 1, 1);
    run(1, 1, 0);
    cur_req = "R4";   // retrigger mid-count
    run(7, 1, 1);

    cur_req = "R7";
    step(0, 1, 1, 3, 2);
    run_alt(12, 1);
    run(1, 1, 0);
    cur_req = "R4";
    run(5, 1, 1);

    cur_req = "R8";
    step(0, 1, 1, 5, 3);
    run(12, 1, 1);
    step(0, 1, 1, 4, 3);
    run(10, 1, 1);
    step(0, 1, 1, 1, 3);
    run(4, 1, 1);
    step(0, 1, 1, 2, 3);
    run(5, 1, 1);

    cur_req = "R9";   // hardware strobe
    step(0, 0, 1, 3, 5);
    run(2, 1, 0);
    run(8, 1, 1);

    cur_req = "R11";
    step(0, 1, 1, 4, 6);
    run(9, 1, 1);
    step(0, 1, 1, 3, 7);
    run(8, 1, 1);

    cur_req = "R2";   // load wins over tick and gate rise
    step(0, 0, 1, 9, 2);
    step(1, 1, 1, 7, 2);
    run(3, 1, 1);
    step(0, 1, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule